// File: doc/BRIEF.md
# Incrementing Pattern Memory Tester

This block is a hardware self-test engine for a contiguous memory range. A one-cycle start pulse captures a byte base address, a byte length, an access width and a compare mask. The engine then makes three sequential passes over the range through a simple synchronous memory port. The first pass fills each location with its own word index. The second pass reads each location, checks it, and at once writes the bitwise inverse of the expected value back to the same location. The third pass reads the range again and checks it against those inverses.

Testing does not stop at the first mismatch. A saturating counter totals the failing accesses. Only the first failure is recorded, with its address and a code that tells whether the fault showed in the true-pattern check or in the complement check. The memory port expects read data one clock after a read is issued. Typical uses are at power-up or after a board change, to find stuck or shorted data lines.

Top module: `incr_pattern_tester`

## Requirements
- R1: After reset, done, pass, mem_en, err_count and first_fail_code are all 0.
- R2: Access width code 0, 1, 2 and 3 selects 1, 2, 4 and 8 bytes. Pass one writes, in ascending order, the value i truncated to the access width to byte address base + i*width, for i = 0..N-1. mem_size carries the code, and the unused upper bits of mem_wdata are 0.
- R3: Pass two handles each i in ascending order. It issues a read of that address and, on the next cycle, writes the inverse of the truncated value of i to the same address.
- R4: Pass three reads every address again in ascending order and compares each one with the inverse written in pass two.
- R5: first_fail_code is 0 when there is no error, 1 when the first error was a pass-two mismatch, and 2 when it was a pass-three mismatch.
- R6: A data bit takes part in a comparison only if it is set in cmp_mask and lies within the access width.
- R7: Every mismatching read adds one to err_count, which holds at 2^ERR_W-1 once it reaches it. The test runs to the end whatever the number of errors.
- R8: first_fail_addr and first_fail_code record the first mismatching read of a run, and later errors leave them unchanged. A new start clears them.
- R9: N = length >> code, so a partial final access is dropped. N = 0 makes no memory access and reaches done with pass.
- R10: done stays high until the next accepted start. pass is high only when done is high and err_count is 0. A start during a run is ignored.
- R11: done first reads high 5N+1 rising edges after the edge that samples start, counting that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test; accepted when idle or done |
| base_addr | input | ADDR_W | Byte address of the first location |
| length | input | ADDR_W | Range length in bytes |
| acc_size | input | 2 | Access width code (0..3 = 8/16/32/64 bits) |
| cmp_mask | input | 64 | Bits that take part in comparison |
| done | output | 1 | Test finished |
| pass | output | 1 | Finished with no errors |
| err_count | output | ERR_W | Saturating mismatch count |
| first_fail_addr | output | ADDR_W | Address of the first mismatch |
| first_fail_code | output | 2 | Kind of the first mismatch |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | 64 | Write data, low-aligned |
| mem_rdata | input | 64 | Read data, valid one cycle after the read |

## Verification
Every memory command is checked in the same cycle it is issued, on the falling edge. The expected access stream is built before start from the requirements. The stored value the engine should read back is found from a byte-wise model of the injected stuck bit, so the expected value is ready when the compare cycle arrives. The final results are only checked once done is high, which R11 places at rising edge 5N+1. The bench counts those edges, then checks err_count, the first-failure fields and pass together on that falling edge. It also checks that done is still high three cycles later.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_TRUE = 2'd1,
    ERR_COMP = 2'd2
  } err_code_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FILL, S_RD_T, S_CK_T, S_RD_C, S_CK_C, S_DONE
  } tst_state_t;
endpackage

// File: rtl/mt_pattern.sv
module mt_pattern import mt_pkg::*; #(
  parameter int IDX_W = 16
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] pat_true,
  output logic [DATA_W-1:0] pat_comp,
  output logic [DATA_W-1:0] lane
);
  logic [DATA_W-1:0] ext;

  assign ext = DATA_W'(idx);

  always_comb begin
    case (size)
      2'd0:    lane = DATA_W'(64'h0000_0000_0000_00FF);
      2'd1:    lane = DATA_W'(64'h0000_0000_0000_FFFF);
      2'd2:    lane = DATA_W'(64'h0000_0000_FFFF_FFFF);
      default: lane = '1;
    endcase
  end

  assign pat_true = ext & lane;
  assign pat_comp = ~ext & lane;
endmodule

// File: rtl/mt_walker.sv
module mt_walker #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] count,
  output logic [ADDR_W-1:0] idx,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [ADDR_W-1:0] stride;

  assign stride = ADDR_W'(1) << size;
  assign last   = (idx == count - ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      addr <= '0;
    end else if (load) begin
      idx  <= '0;
      addr <= load_addr;
    end else if (step) begin
      idx  <= idx + ADDR_W'(1);
      addr <= addr + stride;
    end
  end
endmodule

// File: rtl/mt_err_log.sv
module mt_err_log import mt_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              chk_valid,
  input  logic              chk_fail,
  input  err_code_t         chk_code,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [ERR_W-1:0]  err_count,
  output logic [ADDR_W-1:0] first_addr,
  output err_code_t         first_code
);
  localparam logic [ERR_W-1:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      err_count  <= '0;
      first_addr <= '0;
      first_code <= ERR_NONE;
    end else if (chk_valid && chk_fail) begin
      if (err_count == '0) begin
        first_addr <= chk_addr;
        first_code <= chk_code;
      end
      if (err_count != SAT) err_count <= err_count + ERR_W'(1);
    end
  end
endmodule

// File: rtl/incr_pattern_tester.sv
module incr_pattern_tester import mt_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] length,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] cmp_mask,
  output logic              done,
  output logic              pass,
  output logic [ERR_W-1:0]  err_count,
  output logic [ADDR_W-1:0] first_fail_addr,
  output logic [1:0]        first_fail_code,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  tst_state_t        state_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] mask_q;
  logic [ADDR_W-1:0] base_q, count_q, req_count;
  logic              accept, w_load, w_step, last;
  logic [ADDR_W-1:0] idx, waddr;
  logic [DATA_W-1:0] pat_t, pat_c, lane, expect_w;
  logic              chk_valid, chk_fail;
  err_code_t         chk_code, first_code_w;

  assign req_count = length >> acc_size;
  assign accept    = start && (state_q == S_IDLE || state_q == S_DONE);
  assign w_load    = accept || (last && (state_q == S_FILL || state_q == S_CK_T));
  assign w_step    = !w_load &&
                     (state_q == S_FILL || state_q == S_CK_T || state_q == S_CK_C);

  mt_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst(rst), .load(w_load), .step(w_step),
    .load_addr(accept ? base_addr : base_q), .size(size_q), .count(count_q),
    .idx(idx), .addr(waddr), .last(last)
  );

  mt_pattern #(.IDX_W(ADDR_W)) u_pat (
    .idx(idx), .size(size_q), .pat_true(pat_t), .pat_comp(pat_c), .lane(lane)
  );

  // Sequencer: phase order fill -> read/invert -> read-back.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      size_q  <= '0;
      mask_q  <= '1;
      base_q  <= '0;
      count_q <= '0;
    end else begin
      case (state_q)
        S_IDLE, S_DONE: if (accept) begin
          size_q  <= acc_size;
          mask_q  <= cmp_mask;
          base_q  <= base_addr;
          count_q <= req_count;
          state_q <= (req_count == '0) ? S_DONE : S_FILL;
        end
        S_FILL:  if (last) state_q <= S_RD_T;
        S_RD_T:  state_q <= S_CK_T;
        S_CK_T:  state_q <= last ? S_RD_C : S_RD_T;
        S_RD_C:  state_q <= S_CK_C;
        S_CK_C:  state_q <= last ? S_DONE : S_RD_C;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // Memory command decoded from the state register.
  assign mem_en    = (state_q == S_FILL) || (state_q == S_RD_T) ||
                     (state_q == S_CK_T) || (state_q == S_RD_C);
  assign mem_we    = (state_q == S_FILL) || (state_q == S_CK_T);
  assign mem_addr  = waddr;
  assign mem_size  = size_q;
  assign mem_wdata = (state_q == S_FILL) ? pat_t :
                     (state_q == S_CK_T) ? pat_c : '0;

  // One shared masked comparator for both checking phases.
  assign chk_valid = (state_q == S_CK_T) || (state_q == S_CK_C);
  assign expect_w  = (state_q == S_CK_T) ? pat_t : pat_c;
  assign chk_fail  = |((mem_rdata ^ expect_w) & mask_q & lane);
  assign chk_code  = (state_q == S_CK_T) ? ERR_TRUE : ERR_COMP;

  mt_err_log #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_log (
    .clk(clk), .rst(rst), .clear(accept),
    .chk_valid(chk_valid), .chk_fail(chk_fail), .chk_code(chk_code),
    .chk_addr(waddr), .err_count(err_count),
    .first_addr(first_fail_addr), .first_code(first_code_w)
  );

  assign first_fail_code = first_code_w;
  assign done = (state_q == S_DONE);
  assign pass = done && (err_count == '0);
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
  parameter int ADDR_W = 16,
  parameter int ERR_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ERR_W-1:0]  err_count,
  input logic [ADDR_W-1:0] first_fail_addr,
  input logic [1:0]        first_fail_code
);
  // R3
  we_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_en);

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(err_count)));

  // R5
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    first_fail_code != 2'd3);

  // R5
  code_with_count_chk: assert property (@(posedge clk) disable iff (rst)
    (err_count != '0) |-> (first_fail_code != 2'd0));

  // R7
  count_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> (err_count >= $past(err_count)));

  // R7
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    ((err_count == '1) && !start) |=> (err_count == '1));

  // R8
  first_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((err_count != '0) && !start) |=>
      ($stable(first_fail_addr) && $stable(first_fail_code)));
endmodule

bind incr_pattern_tester mt_checker #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done),
  .mem_en(mem_en), .mem_we(mem_we), .err_count(err_count),
  .first_fail_addr(first_fail_addr), .first_fail_code(first_fail_code)
);

// File: tb/sim_incr_pattern_tester.sv
`timescale 1ns/1ps
module sim_incr_pattern_tester;
  localparam int AW = 12;
  localparam int EW = 4;
  localparam int MEMB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0, length = '0;
  logic [1:0]    acc_size = '0;
  logic [63:0]   cmp_mask = '1;
  logic          done, pass, mem_en, mem_we;
  logic [EW-1:0] err_count;
  logic [AW-1:0] first_fail_addr, mem_addr;
  logic [1:0]    first_fail_code, mem_size;
  logic [63:0]   mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  incr_pattern_tester #(.ADDR_W(AW), .ERR_W(EW)) u0 (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .length(length), .acc_size(acc_size), .cmp_mask(cmp_mask),
    .done(done), .pass(pass), .err_count(err_count),
    .first_fail_addr(first_fail_addr), .first_fail_code(first_fail_code),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int nvec = 0, nfail = 0;

  // Injectable stuck bit: one byte, or every byte when stuck_all.
  bit          stuck_on = 0, stuck_all = 0, stuck_val = 0;
  logic [AW-1:0] stuck_addr = '0;
  int          stuck_bit = 0;

  function automatic logic [7:0] fault(input logic [AW-1:0] a, input logic [7:0] v);
    logic [7:0] r = v;
    if (stuck_on && (stuck_all || a == stuck_addr)) r[stuck_bit] = stuck_val;
    return r;
  endfunction

  function automatic logic [63:0] stored(input logic [AW-1:0] a, input logic [1:0] sz,
                                         input logic [63:0] v);
    logic [63:0] r = '0;
    for (int b = 0; b < (1 << sz); b++) r[b*8 +: 8] = fault(a + AW'(b), v[b*8 +: 8]);
    return r;
  endfunction

  function automatic logic [63:0] lane_of(input logic [1:0] sz);
    case (sz)
      2'd0: return 64'hFF;
      2'd1: return 64'hFFFF;
      2'd2: return 64'hFFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  // Behavioural byte memory, one-cycle read latency.
  logic [7:0] mem [0:MEMB-1];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < (1 << mem_size); b++)
          mem[mem_addr + AW'(b)] = fault(mem_addr + AW'(b), mem_wdata[b*8 +: 8]);
      end else begin
        logic [63:0] r;
        r = '0;
        for (int b = 0; b < (1 << mem_size); b++) r[b*8 +: 8] = mem[mem_addr + AW'(b)];
        mem_rdata <= r;
      end
    end
  end

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [1:0]    sz;
    logic [63:0]   data;
    logic [1:0]    ph;
  } txn_t;
  txn_t exp_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Monitor: every issued memory command is popped and compared.
  always @(negedge clk) begin
    if (!rst && mem_en) begin
      if (exp_q.size() == 0) begin
        check(0, "R9", "unexpected access addr", longint'(mem_addr), 0);
      end else begin
        txn_t t;
        bit ok;
        string tag;
        t = exp_q.pop_front();
        ok = (mem_we == t.we) && (mem_addr == t.addr) && (mem_size == t.sz) &&
             (!t.we || mem_wdata == t.data);
        tag = (t.ph == 2'd1) ? "R2" : (t.ph == 2'd2) ? "R3" : "R4";
        check(ok, tag, $sformatf("access we=%0b addr", mem_we),
              longint'({mem_addr, mem_wdata[15:0]}), longint'({t.addr, t.data[15:0]}));
      end
    end
  end

  task automatic run(input logic [AW-1:0] base, input logic [AW-1:0] len,
                     input logic [1:0] sz, input logic [63:0] mask, input bit poke);
    int n = int'(len >> sz);
    int stp = 1 << sz;
    logic [63:0] ln = lane_of(sz);
    int errs = 0;
    logic [AW-1:0] fa = '0;
    int fc = 0;
    int cyc = 0;
    int expc;
    for (int i = 0; i < n; i++)
      exp_q.push_back('{1'b1, base + AW'(i*stp), sz, 64'(i) & ln, 2'd1});
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a = base + AW'(i*stp);
      logic [63:0] v = 64'(i) & ln;
      exp_q.push_back('{1'b0, a, sz, 64'd0, 2'd2});
      exp_q.push_back('{1'b1, a, sz, ~64'(i) & ln, 2'd2});
      if (((stored(a, sz, v) ^ v) & mask & ln) != 0) begin
        if (errs == 0) begin fa = a; fc = 1; end
        errs++;
      end
    end
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a = base + AW'(i*stp);
      logic [63:0] v = ~64'(i) & ln;
      exp_q.push_back('{1'b0, a, sz, 64'd0, 2'd3});
      if (((stored(a, sz, v) ^ v) & mask & ln) != 0) begin
        if (errs == 0) begin fa = a; fc = 2; end
        errs++;
      end
    end
    expc = (errs > 15) ? 15 : errs;
    @(negedge clk);
    start = 1; base_addr = base; length = len; acc_size = sz; cmp_mask = mask;
    do begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (cyc == 1) start = 0;
      if (poke && cyc == 3) begin // R10: start while busy, other settings
        start = 1; base_addr = 12'h7F0; length = 12'h10; acc_size = 2'd3; cmp_mask = '0;
      end
      if (poke && cyc == 4) start = 0;
    end while (!done && cyc < 20000);
    check(cyc == 5*n + 1, "R11", "cycles to done", cyc, 5*n + 1);
    check(exp_q.size() == 0, "R2", "accesses left", exp_q.size(), 0);
    exp_q.delete();
    check(err_count == EW'(expc), "R7", "err_count", err_count, expc);
    check(first_fail_code == 2'(fc), "R5", "first code", first_fail_code, fc);
    if (errs != 0)
      check(first_fail_addr == fa, "R8", "first addr", first_fail_addr, fa);
    check(pass == (errs == 0), "R10", "pass", pass, errs == 0);
    repeat (3) @(negedge clk);
    check(done && !mem_en, "R10", "done held", done, 1);
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMB; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1 reset state
    check(!done && !pass && !mem_en && err_count == 0 && first_fail_code == 0,
          "R1", "reset outputs", {done, pass, mem_en}, 0);
    // R2 byte width, pattern wraps past 255; R10 start ignored mid-run
    run(12'h100, 12'd300, 2'd0, '1, 1);
    // R9 64-bit, 70 bytes truncate to 8 accesses
    run(12'h200, 12'd70, 2'd3, '1, 0);
    // R5 stuck-at-1 on byte 0x305 bit 2: pass-two error, 16-bit access
    stuck_on = 1; stuck_addr = 12'h305; stuck_bit = 2; stuck_val = 1;
    run(12'h300, 12'd16, 2'd1, '1, 0);
    // R4 stuck-at-0 same bit: pass-three error, 32-bit access
    stuck_val = 0;
    run(12'h300, 12'd8, 2'd2, '1, 0);
    // R6 mask hides bit 10 (byte 1 bit 2): clean result
    stuck_val = 1;
    run(12'h300, 12'd16, 2'd1, ~(64'd1 << 10), 0);
    // R7 R8 every byte bit 0 stuck high: 40 errors saturate at 15
    stuck_all = 1; stuck_bit = 0;
    run(12'h000, 12'd40, 2'd0, '1, 0);
    stuck_on = 0; stuck_all = 0;
    // R9 length smaller than one access
    run(12'h080, 12'd3, 2'd2, '1, 0);
    // clean run after failures clears the log
    run(12'h400, 12'd32, 2'd2, '1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule